// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block joins two parallel data buses, called A and B, and moves a word from one to the other. Each side owns a capture register. The side being driven receives either the word now present on the other bus, which passes straight through, or the word last captured from that bus. Each bus uses three plain ports: an input, an output and an output enable. This keeps tri-state logic out of the core. A pad ring or a bus fabric can merge the three ports into a true bidirectional line.

One active-low enable and one direction bit decide which side, if any, is driven. Two select bits, one per direction, pick live data or stored data. Each register loads when its capture strobe rises. The strobe is sampled by the core clock. Loading takes place whatever the enable and direction are set to, so a bus can be recorded while both sides are isolated. When the driven side shows stored data, a new capture shows up on that side in the cycle right after the capture edge.

The drive decision is an enumerated mode with three values:
- `MODE_ISOLATE`: no side driven.
- `MODE_DRIVE_B`: B driven from the A path.
- `MODE_DRIVE_A`: A driven from the B path.

The mode is a purely combinational function of the enable and direction. Every change in those two inputs is a transition between modes, with no clock delay:
- enable high moves to `MODE_ISOLATE`;
- enable low with direction high moves to `MODE_DRIVE_B`;
- enable low with direction low moves to `MODE_DRIVE_A`.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst` is high at a clock edge, both capture registers clear to zero. After reset, a stored-mode output therefore shows 0x00.
- R2: On the first clock edge at which `cap_a` is sampled high after being low at the previous edge, the A register loads `a_in`. Otherwise it holds its value.
- R3: On the first clock edge at which `cap_b` is sampled high after being low at the previous edge, the B register loads `b_in`. Otherwise it holds its value.
- R4: Register loading does not depend on `oe_n`, `dir`, `sel_ab` or `sel_ba`. A capture made while both sides are isolated is visible later in stored mode.
- R5: With `oe_n` = 1, both `a_oe` and `b_oe` are 0, and both `a_out` and `b_out` are 0x00.
- R6: With `oe_n` = 0 and `dir` = 1, `b_oe` = 1 and `a_oe` = 0, and `a_out` is 0x00.
- R7: With `oe_n` = 0 and `dir` = 0, `a_oe` = 1 and `b_oe` = 0, and `b_out` is 0x00.
- R8: When B is driven, `b_out` equals `a_in` in the same cycle if `sel_ab` = 0, and equals the A register if `sel_ab` = 1.
- R9: When A is driven, `a_out` equals `b_in` in the same cycle if `sel_ba` = 0, and equals the B register if `sel_ba` = 1.
- R10: In stored mode, the word loaded by a capture edge appears on the driven output in the cycle that follows that edge.
- R11: A capture strobe held high across several edges loads only once. Later changes of the bus input while the strobe stays high are not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the capture strobes |
| rst | input | 1 | Synchronous active-high reset of both registers |
| oe_n | input | 1 | Active-low enable for driving either bus |
| dir | input | 1 | 1: drive B from the A path; 0: drive A from the B path |
| sel_ab | input | 1 | A-to-B source: 0 live `a_in`, 1 stored A register |
| sel_ba | input | 1 | B-to-A source: 0 live `b_in`, 1 stored B register |
| cap_a | input | 1 | A capture strobe; its rising edge loads the A register |
| cap_b | input | 1 | B capture strobe; its rising edge loads the B register |
| a_in | input | WIDTH | Word currently present on bus A |
| a_out | output | WIDTH | Word driven onto bus A (0 when not driven) |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Word currently present on bus B |
| b_out | output | WIDTH | Word driven onto bus B (0 when not driven) |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
Two functions can coincide in one cycle: a capture edge on a register, and that same register feeding the driven bus in stored mode. The bench raises the strobe while B is driven from the A register. It checks that `b_out` still shows the old word before the edge and the new word in the cycle after it. Capture also coincides with isolation or with the opposite direction. Those cases are judged by switching to stored mode afterwards and reading the captured word out at the ports. A full sweep of the enable, direction and both selects against several data words compares every output with values worked out arithmetically in the bench.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_DRIVE_B = 2'd1,
        MODE_DRIVE_A = 2'd2
    } drive_mode_e;

endpackage

// File: rtl/xcvr_capture.sv
// One capture register with rising-edge detection of its strobe.
module xcvr_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strb,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             strb_q
);

    logic load;

    always_comb begin
        load = strb & ~strb_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            strb_q <= 1'b0;
        end else begin
            strb_q <= strb;
            if (load) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/xcvr_drive_ctrl.sv
// Decodes the enable and direction into a drive mode and per-bus enables.
module xcvr_drive_ctrl
    import xcvr_pkg::*;
(
    input  logic        oe_n,
    input  logic        dir,
    output drive_mode_e mode,
    output logic        a_oe,
    output logic        b_oe
);

    always_comb begin
        if (oe_n) begin
            mode = MODE_ISOLATE;
        end else if (dir) begin
            mode = MODE_DRIVE_B;
        end else begin
            mode = MODE_DRIVE_A;
        end
    end

    always_comb begin
        a_oe = 1'b0;
        b_oe = 1'b0;
        unique case (mode)
            MODE_ISOLATE: begin
                a_oe = 1'b0;
                b_oe = 1'b0;
            end
            MODE_DRIVE_B: b_oe = 1'b1;
            MODE_DRIVE_A: a_oe = 1'b1;
            default: begin
                a_oe = 1'b0;
                b_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/xcvr_out_mux.sv
// Source selection for one driven side, forced to zero when not enabled.
module xcvr_out_mux #(
    parameter int WIDTH = 8
) (
    input  logic             en,
    input  logic             sel_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] y
);

    always_comb begin
        if (!en) begin
            y = '0;
        end else if (sel_stored) begin
            y = stored;
        end else begin
            y = live;
        end
    end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             cap_a,
    input  logic             cap_b,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    logic [WIDTH-1:0] q_a;
    logic [WIDTH-1:0] q_b;
    logic             cap_a_q;
    logic             cap_b_q;
    drive_mode_e      mode;
    logic             drv_a;
    logic             drv_b;

    xcvr_capture #(.WIDTH(WIDTH)) u_cap_a (
        .clk    (clk),
        .rst    (rst),
        .strb   (cap_a),
        .d      (a_in),
        .q      (q_a),
        .strb_q (cap_a_q)
    );

    xcvr_capture #(.WIDTH(WIDTH)) u_cap_b (
        .clk    (clk),
        .rst    (rst),
        .strb   (cap_b),
        .d      (b_in),
        .q      (q_b),
        .strb_q (cap_b_q)
    );

    xcvr_drive_ctrl u_ctrl (
        .oe_n (oe_n),
        .dir  (dir),
        .mode (mode),
        .a_oe (drv_a),
        .b_oe (drv_b)
    );

    // B side is fed from the A path, A side from the B path.
    xcvr_out_mux #(.WIDTH(WIDTH)) u_mux_b (
        .en         (drv_b),
        .sel_stored (sel_ab),
        .live       (a_in),
        .stored     (q_a),
        .y          (b_out)
    );

    xcvr_out_mux #(.WIDTH(WIDTH)) u_mux_a (
        .en         (drv_a),
        .sel_stored (sel_ba),
        .live       (b_in),
        .stored     (q_b),
        .y          (a_out)
    );

    assign a_oe = drv_a;
    assign b_oe = drv_b;

endmodule

// File: rtl/xcvr_reg_chk.sv
module xcvr_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             oe_n,
    input logic             dir,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic             cap_a,
    input logic             cap_b,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_out,
    input logic             a_oe,
    input logic             b_oe,
    input logic [WIDTH-1:0] q_a,
    input logic [WIDTH-1:0] q_b,
    input logic             cap_a_q,
    input logic             cap_b_q
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (q_a == '0 && q_b == '0));

    a_r2_load_a: assert property (@(posedge clk) disable iff (rst)
        (cap_a && !cap_a_q) |=> q_a == $past(a_in));

    a_r3_load_b: assert property (@(posedge clk) disable iff (rst)
        (cap_b && !cap_b_q) |=> q_b == $past(b_in));

    a_r11_hold_a: assert property (@(posedge clk) disable iff (rst)
        !(cap_a && !cap_a_q) |=> $stable(q_a));

    a_r11_hold_b: assert property (@(posedge clk) disable iff (rst)
        !(cap_b && !cap_b_q) |=> $stable(q_b));

    a_r5_isolate: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

    a_r6_drive_b: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && dir) |-> (b_oe && !a_oe && a_out == '0));

    a_r7_drive_a: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !dir) |-> (a_oe && !b_oe && b_out == '0));

    a_r8_b_source: assert property (@(posedge clk) disable iff (rst)
        b_oe |-> (b_out == (sel_ab ? q_a : a_in)));

    a_r9_a_source: assert property (@(posedge clk) disable iff (rst)
        a_oe |-> (a_out == (sel_ba ? q_b : b_in)));

    always_comb begin
        a_r6_one_enable: assert (!(a_oe && b_oe));
    end

endmodule

bind bus_xcvr_reg xcvr_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .oe_n    (oe_n),
    .dir     (dir),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .cap_a   (cap_a),
    .cap_b   (cap_b),
    .a_in    (a_in),
    .b_in    (b_in),
    .a_out   (a_out),
    .b_out   (b_out),
    .a_oe    (a_oe),
    .b_oe    (b_oe),
    .q_a     (q_a),
    .q_b     (q_b),
    .cap_a_q (cap_a_q),
    .cap_b_q (cap_b_q)
);

// File: tb/bus_xcvr_reg_bench.sv
`timescale 1ns/1ps
module bus_xcvr_reg_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         oe_n, dir, sel_ab, sel_ba, cap_a, cap_b;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [W-1:0] ra, rb;

    always #2 clk = ~clk;

    bus_xcvr_reg #(.WIDTH(W)) u_bus_xcvr_reg (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare all outputs with the bench model for the current inputs.
    task automatic chk_all(input string tag);
        logic         ea, eb;
        logic [W-1:0] ya, yb;
        ea = !oe_n && !dir;
        eb = !oe_n && dir;
        yb = eb ? (sel_ab ? ra : a_in) : '0;
        ya = ea ? (sel_ba ? rb : b_in) : '0;
        chk({tag, " a_oe"}, {7'd0, a_oe}, {7'd0, ea});
        chk({tag, " b_oe"}, {7'd0, b_oe}, {7'd0, eb});
        chk({tag, " a_out"}, a_out, ya);
        chk({tag, " b_out"}, b_out, yb);
    endtask

    // Raise a strobe for one cycle; the register loads at the next edge.
    task automatic pulse_a(input logic [W-1:0] v);
        @(negedge clk); a_in = v; cap_a = 1'b1;
        @(negedge clk); cap_a = 1'b0; ra = v;
    endtask

    task automatic pulse_b(input logic [W-1:0] v);
        @(negedge clk); b_in = v; cap_b = 1'b1;
        @(negedge clk); cap_b = 1'b0; rb = v;
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; oe_n = 1'b1; dir = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
        cap_a = 1'b0; cap_b = 1'b0; a_in = 8'h3C; b_in = 8'hC3;
        ra = '0; rb = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: stored paths read zero after reset
        @(negedge clk); oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
        chk("R1 b_out stored after reset", b_out, 8'h00);
        dir = 1'b0; sel_ba = 1'b1; #1;
        chk("R1 a_out stored after reset", a_out, 8'h00);

        // R4: capture while isolated, then read back in stored mode
        oe_n = 1'b1;
        pulse_a(8'h5A);
        pulse_b(8'hC3);
        @(negedge clk); oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; a_in = 8'h00; #1;
        chk("R4 R2 isolated capture A", b_out, 8'h5A);
        dir = 1'b0; sel_ba = 1'b1; b_in = 8'h00; #1;
        chk("R4 R3 isolated capture B", a_out, 8'hC3);

        // R4: capture against the direction being driven
        @(negedge clk); dir = 1'b1;
        pulse_b(8'h96);
        @(negedge clk); dir = 1'b0; #1;
        chk("R4 R3 capture B while driving B", a_out, 8'h96);

        // R5..R9: sweep of enable, direction, selects with varied data
        for (int p = 0; p < 4; p++) begin
            pulse_a(8'(8'h1D * (p + 1)));
            pulse_b(8'(8'hE7 ^ (p * 8'h33)));
            for (int m = 0; m < 16; m++) begin
                @(negedge clk);
                oe_n   = m[0];
                dir    = m[1];
                sel_ab = m[2];
                sel_ba = m[3];
                a_in   = 8'((p * 37 + m * 11) ^ 8'hA5);
                b_in   = 8'((p * 53 + m * 7) ^ 8'h4B);
                #1;
                chk_all($sformatf("R5 R6 R7 R8 R9 p%0d m%0d", p, m));
            end
        end

        // R2, R3: no strobe, inputs move, registers hold
        @(negedge clk); a_in = 8'hFF; b_in = 8'hEE;
        repeat (3) @(negedge clk);
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
        chk("R2 hold without strobe", b_out, ra);
        dir = 1'b0; sel_ba = 1'b1; #1;
        chk("R3 hold without strobe", a_out, rb);

        // R10: capture edge while that register feeds the driven side
        @(negedge clk); dir = 1'b1; sel_ab = 1'b1; a_in = 8'h71; cap_a = 1'b1; #1;
        chk("R10 old value before edge", b_out, ra);
        @(negedge clk); #1;
        chk("R10 new value after edge", b_out, 8'h71);
        ra = 8'h71;

        // R11: strobe held high, later data not recorded
        a_in = 8'h0F;
        @(negedge clk); a_in = 8'hF0;
        @(negedge clk); #1;
        chk("R11 held strobe loads once", b_out, 8'h71);
        cap_a = 1'b0;
        dir = 1'b0;
        @(negedge clk); b_in = 8'h22; cap_b = 1'b1;
        @(negedge clk); b_in = 8'h44;
        @(negedge clk); cap_b = 1'b0; #1;
        chk("R11 R10 held strobe B", a_out, 8'h22);

        // R2 re-arm after strobe release
        pulse_a(8'hB4);
        @(negedge clk); dir = 1'b1; a_in = 8'h00; #1;
        chk("R2 reload after release", b_out, 8'hB4);

        // R1: reset mid-run clears stored data
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk("R1 reset mid-run A", b_out, 8'h00);
        dir = 1'b0; #1;
        chk("R1 reset mid-run B", a_out, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule